// File: doc/BRIEF.md
# UART Receive FIFO and Status Registers

This block is the receive side of a UART as software sees it. Bytes from a deserializer arrive on a one-cycle valid strobe with their parity and framing error flags. A separate strobe reports a line break. The block either queues these bytes in a parameterised byte FIFO or, when queueing is off, keeps only the latest byte in a holding register. Software reaches the block through a 32-bit word-aligned register port. Reads return data in the same cycle, and every side effect of an access takes hold at the next clock edge.

Two single-cycle event pulses go to an interrupt controller. One marks each arrival. The other marks a lost byte or a read that found nothing to return. The transmit FIFO lies outside this block. Its occupancy and full flag are only mirrored into the FIFO status word, and a one-cycle clear pulse is produced for it.

Top module: `uart_rxf_top`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x6, and the control word (0x00), error word (0x08) and FIFO status word (0x0C) all read 0.
- R2: Control bit 0 turns FIFO mode on and reads back. Bits 1 and 2 always read 0. Writing 1 to bit 2 makes `tx_fifo_clr` high for exactly the cycle after the write.
- R3: Writing 1 to control bit 1 empties the receive FIFO. A byte arriving in the same cycle is discarded.
- R4: The FIFO status word carries the receive count in bits 7:0 and the receive-full flag in bit 8. When the FIFO holds DEPTH bytes, bits 7:0 read 0 and bit 8 reads 1. Bits 23:16 mirror `tx_count` and bit 24 mirrors `tx_full`.
- R5: In FIFO mode a read of the receive buffer (0x10) returns the oldest byte in bits 7:0 and removes it. Status bit 0 (data ready) is 1 exactly while the FIFO is not empty.
- R6: In FIFO mode a read of the receive buffer while the FIFO is empty returns 0, and `evt_err` pulses in the next cycle.
- R7: A byte arriving at a full FIFO is dropped, sets the overrun flag and pulses `evt_err`. Every arrival, dropped or not, pulses `evt_rx` in the next cycle.
- R8: The error word holds overrun in bit 0, parity in bit 1, frame in bit 2 and break in bit 3. Reading it returns the value and clears it. A flag raised in the same cycle as the read survives the read.
- R9: With FIFO mode off, an arriving byte goes to the holding register and sets data ready. A read of 0x10 returns that byte and clears data ready. An arrival while data ready is set overwrites the byte, sets overrun and pulses `evt_err`.
- R10: A break strobe is handled as the arrival of a 0x00 byte and also sets the break flag.
- R11: Writes to offsets 0x04, 0x08, 0x0C and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the edge) |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | One incoming byte this cycle |
| rx_data | input | 8 | Incoming byte |
| rx_par_err | input | 1 | Parity error of the incoming byte |
| rx_frm_err | input | 1 | Framing error of the incoming byte |
| rx_break | input | 1 | Line break detected this cycle |
| tx_count | input | 8 | Transmit FIFO occupancy to mirror |
| tx_full | input | 1 | Transmit FIFO full flag to mirror |
| evt_rx | output | 1 | Receive event pulse |
| evt_err | output | 1 | Error event pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |

## Verification
Assertions run on every cycle. They check that the FIFO count never passes DEPTH, that a push into a full FIFO leaves the count unchanged, that a clear empties the FIFO and that an error-word read with no new arrival leaves it zero. They also check that a read of an empty FIFO and a transmit clear request each produce their pulse one cycle later. The scenarios cover the rest. These are the first-in-first-out byte order, the status encoding at every fill level including the full point, flags raised in the same cycle as a read, break bytes, ignored writes, and the holding-register path for all 256 byte values.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
    // word index of each register (byte offset / 4)
    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_ERR   = 2;
    localparam int IDX_FSTAT = 3;
    localparam int IDX_RXBUF = 4;

    // control bits
    localparam int CTRL_EN    = 0;
    localparam int CTRL_RXCLR = 1;
    localparam int CTRL_TXCLR = 2;

    // error word bits
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

    typedef struct packed {
        logic [7:0] hold;
        logic       hold_vld;
        logic       fifo_en;
        logic [3:0] err;
        logic       evt_rx;
        logic       evt_err;
        logic       tx_clr;
    } rxf_state_t;
endpackage

// File: rtl/rxf_queue.sv
module rxf_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [PW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
    } ptr_t;

    ptr_t       ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    assign count   = ptr_q.wp - ptr_q.rp;
    assign full    = (count == PW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[ptr_q.rp[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wp = ptr_q.wp + 1'b1;
            if (do_pop)  ptr_d.rp = ptr_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp[AW-1:0]] <= din;
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
    // R3
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/rxf_rdmux.sv
module rxf_rdmux #(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx,
    input  logic          fifo_en,
    input  logic          rdy,
    input  logic [3:0]    err,
    input  logic [7:0]    rx_cnt,
    input  logic          rx_full,
    input  logic [7:0]    tx_cnt,
    input  logic          tx_full,
    input  logic [7:0]    rxbuf,
    output logic [31:0]   rdata
);
    import uart_rxf_pkg::*;

    always_comb begin
        rdata = '0;
        case (idx)
            IW'(IDX_CTRL):  rdata[CTRL_EN] = fifo_en;
            IW'(IDX_STAT):  rdata[2:0] = {2'b11, rdy};
            IW'(IDX_ERR):   rdata[3:0] = err;
            IW'(IDX_FSTAT): rdata = {7'b0, tx_full, tx_cnt, 7'b0, rx_full,
                                     rx_full ? 8'h00 : rx_cnt};
            IW'(IDX_RXBUF): rdata[7:0] = rxbuf;
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rxf_top.sv
module uart_rxf_top #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_break,
    input  logic [7:0]        tx_count,
    input  logic              tx_full,
    output logic              evt_rx,
    output logic              evt_err,
    output logic              tx_fifo_clr
);
    import uart_rxf_pkg::*;

    localparam int IW = ADDR_W - 2;
    localparam int PW = $clog2(DEPTH) + 1;

    rxf_state_t    s_d, s_q;
    logic [IW-1:0] idx;
    logic          wr_ctrl, rd_err, rd_rxbuf, arrive;
    logic [7:0]    in_byte, q_dout, cnt8, rxbuf_val;
    logic [PW-1:0] q_count;
    logic          q_full, q_empty, q_push, q_pop, q_clr, rdy;
    logic          unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:3]};
    assign idx      = bus_addr[ADDR_W-1:2];
    assign wr_ctrl  = bus_wr && (idx == IW'(IDX_CTRL));
    assign rd_err   = bus_rd && (idx == IW'(IDX_ERR));
    assign rd_rxbuf = bus_rd && (idx == IW'(IDX_RXBUF));
    assign arrive   = rx_valid || rx_break;
    assign in_byte  = rx_break ? 8'h00 : rx_data;
    assign q_push   = s_q.fifo_en && arrive;
    assign q_pop    = s_q.fifo_en && rd_rxbuf;
    assign q_clr    = wr_ctrl && bus_wdata[CTRL_RXCLR];

    rxf_queue #(.DEPTH(DEPTH), .W(8)) u_queue (
        .clk(clk), .rst_n(rst_n), .clr(q_clr), .push(q_push), .pop(q_pop),
        .din(in_byte), .dout(q_dout), .count(q_count), .full(q_full),
        .empty(q_empty)
    );

    assign cnt8      = {{(8-PW){1'b0}}, q_count};
    assign rdy       = s_q.fifo_en ? !q_empty : s_q.hold_vld;
    assign rxbuf_val = s_q.fifo_en ? (q_empty ? 8'h00 : q_dout) : s_q.hold;

    rxf_rdmux #(.IW(IW)) u_rdmux (
        .idx(idx), .fifo_en(s_q.fifo_en), .rdy(rdy), .err(s_q.err),
        .rx_cnt(cnt8), .rx_full(q_full), .tx_cnt(tx_count), .tx_full(tx_full),
        .rxbuf(rxbuf_val), .rdata(bus_rdata)
    );

    always_comb begin
        logic       ovr;
        logic [3:0] new_err;
        s_d         = s_q;
        s_d.evt_rx  = arrive;
        s_d.tx_clr  = wr_ctrl && bus_wdata[CTRL_TXCLR];
        ovr         = 1'b0;
        new_err     = '0;
        if (s_q.fifo_en) begin
            ovr = arrive && q_full && !q_clr;
        end else begin
            if (arrive) begin
                ovr        = s_q.hold_vld && !rd_rxbuf;
                s_d.hold   = in_byte;
                s_d.hold_vld = 1'b1;
            end else if (rd_rxbuf) begin
                s_d.hold_vld = 1'b0;
            end
        end
        new_err[ERR_OVR] = ovr;
        new_err[ERR_PAR] = rx_valid && !rx_break && rx_par_err;
        new_err[ERR_FRM] = rx_valid && !rx_break && rx_frm_err;
        new_err[ERR_BRK] = rx_break;
        s_d.err     = (rd_err ? 4'h0 : s_q.err) | new_err;
        s_d.evt_err = ovr || (s_q.fifo_en && rd_rxbuf && q_empty);
        if (wr_ctrl) s_d.fifo_en = bus_wdata[CTRL_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_rx      = s_q.evt_rx;
    assign evt_err     = s_q.evt_err;
    assign tx_fifo_clr = s_q.tx_clr;

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !arrive) |=> (s_q.err == 4'h0));
    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fifo_en && rd_rxbuf && q_empty) |=> evt_err);
    // R2
    txclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CTRL_TXCLR]) |=> tx_fifo_clr);
    // R7
    rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> evt_rx);
    // R9
    hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.fifo_en && rx_valid && !wr_ctrl) |=> s_q.hold_vld);
endmodule

// File: tb/sim_uart_rxf_top.sv
module sim_uart_rxf_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_break = 0;
    logic [7:0]  rx_data = '0, tx_count = '0;
    logic        tx_full = 0, evt_rx, evt_err, tx_fifo_clr;
    int          checks = 0, errors = 0, cycles = 0;
    logic        ev_rx, ev_err, ev_tc;
    logic [31:0] rd;

    localparam int DEPTH = 16;

    always #4 clk = ~clk;

    uart_rxf_top #(.DEPTH(DEPTH), .ADDR_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_break(rx_break), .tx_count(tx_count),
        .tx_full(tx_full), .evt_rx(evt_rx), .evt_err(evt_err),
        .tx_fifo_clr(tx_fifo_clr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ev_rx = evt_rx; ev_err = evt_err; ev_tc = tx_fifo_clr;
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        bus_wr = 1; bus_addr = 6'(off); bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rdr(input int off, output logic [31:0] d);
        bus_rd = 1; bus_addr = 6'(off);
        #1 d = bus_rdata;
        tick();
        bus_rd = 0;
    endtask

    task automatic push(input logic [7:0] b, input logic par, input logic frm, input logic brk);
        rx_valid = !brk; rx_data = b; rx_par_err = par; rx_frm_err = frm; rx_break = brk;
        tick();
        rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_break = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        rdr(32'h04, rd); chk("R1 status", rd, 32'h6);
        rdr(32'h00, rd); chk("R1 ctrl", rd, 0);
        rdr(32'h08, rd); chk("R1 err", rd, 0);
        rdr(32'h0C, rd); chk("R1 fstat", rd, 0);
        // R2 control
        wr(32'h00, 32'h5); chk("R2 txclr pulse", ev_tc, 1);
        tick();             chk("R2 txclr single", ev_tc, 0);
        rdr(32'h00, rd);    chk("R2 ctrl readback", rd, 32'h1);
        // R4 R5 R7 fill sweep
        for (int n = 0; n < DEPTH; n++) begin
            rdr(32'h0C, rd); chk("R4 count", rd, 32'(n));
            rdr(32'h04, rd); chk("R5 ready", rd, (n > 0) ? 32'h7 : 32'h6);
            push(8'(n * 7 + 3), 0, 0, 0);
            chk("R7 evt_rx", ev_rx, 1); chk("R7 no evt_err", ev_err, 0);
        end
        rdr(32'h0C, rd); chk("R4 full", rd, 32'h100);
        push(8'hEE, 0, 0, 0);
        chk("R7 overflow evt_err", ev_err, 1); chk("R7 overflow evt_rx", ev_rx, 1);
        rdr(32'h0C, rd); chk("R7 still full", rd, 32'h100);
        rdr(32'h08, rd); chk("R8 overrun bit", rd, 32'h1);
        rdr(32'h08, rd); chk("R8 clear on read", rd, 0);
        // R5 drain in order
        for (int n = 0; n < DEPTH; n++) begin
            rdr(32'h10, rd); chk("R5 pop order", rd, 32'(8'(n * 7 + 3)));
            chk("R5 no err", ev_err, 0);
            rdr(32'h0C, rd); chk("R5 count after pop", rd, 32'(DEPTH - 1 - n));
        end
        rdr(32'h04, rd); chk("R5 ready clear", rd, 32'h6);
        // R6 empty read
        rdr(32'h10, rd); chk("R6 empty data", rd, 0); chk("R6 evt_err", ev_err, 1);
        // R8 flags
        push(8'h10, 1, 0, 0); rdr(32'h08, rd); chk("R8 parity", rd, 32'h2);
        push(8'h20, 0, 1, 0); rdr(32'h08, rd); chk("R8 frame", rd, 32'h4);
        bus_rd = 1; bus_addr = 6'h08; rx_valid = 1; rx_data = 8'h30; rx_frm_err = 1;
        #1 rd = bus_rdata;
        tick();
        bus_rd = 0; rx_valid = 0; rx_frm_err = 0;
        chk("R8 read before set", rd, 0);
        rdr(32'h08, rd); chk("R8 same-cycle set survives", rd, 32'h4);
        // R3 clear, reset wins over push; R4 tx mirror
        tx_count = 8'h5A; tx_full = 1;
        bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'h3; rx_valid = 1; rx_data = 8'h77;
        tick();
        bus_wr = 0; rx_valid = 0;
        rdr(32'h0C, rd); chk("R3 R4 cleared with tx mirror", rd, 32'h015A0000);
        tx_count = 0; tx_full = 0;
        rdr(32'h00, rd); chk("R3 clear bit reads 0", rd, 32'h1);
        // R10 break
        push(8'hFF, 0, 0, 1);
        chk("R10 evt_rx", ev_rx, 1);
        rdr(32'h0C, rd); chk("R10 count", rd, 32'h1);
        rdr(32'h10, rd); chk("R10 null byte", rd, 0);
        rdr(32'h08, rd); chk("R10 break flag", rd, 32'h8);
        // R11 ignored writes
        push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0);
        wr(32'h04, 32'hFFFFFFFF); wr(32'h08, 32'hFFFFFFFF);
        wr(32'h0C, 32'hFFFFFFFF); wr(32'h10, 32'hFFFFFFFF);
        rdr(32'h0C, rd); chk("R11 count kept", rd, 32'h2);
        rdr(32'h04, rd); chk("R11 status kept", rd, 32'h7);
        rdr(32'h08, rd); chk("R11 err kept", rd, 0);
        rdr(32'h10, rd); chk("R11 data kept", rd, 32'h11);
        // R9 holding register
        wr(32'h00, 32'h0);
        push(8'h41, 0, 0, 0);
        rdr(32'h04, rd); chk("R9 ready", rd, 32'h7);
        push(8'h42, 0, 0, 0); chk("R9 overrun evt", ev_err, 1);
        rdr(32'h08, rd); chk("R9 overrun flag", rd, 32'h1);
        rdr(32'h10, rd); chk("R9 latest byte", rd, 32'h42);
        rdr(32'h04, rd); chk("R9 ready cleared", rd, 32'h6);
        for (int b = 0; b < 256; b++) begin
            push(8'(b), 0, 0, 0);
            rdr(32'h10, rd); chk("R9 byte sweep", rd, 32'(b));
        end
        rdr(32'h08, rd); chk("R9 no overrun in sweep", rd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule